// File: doc/BRIEF.md
# I2C Target to APB Byte Bridge

This block lets an external I2C controller read and write a byte-addressed memory space that sits behind an APB completer. The controller addresses the block by a 7-bit target address taken from a configuration input. In a write transfer, the first two data bytes load a 16-bit pointer, high byte first. Every later byte is stored at the pointer, which then steps up by one. A read transfer returns bytes from consecutive addresses, starting at the pointer. A read usually follows a pointer-setting write and a repeated START.

Both bus lines pass through a digital glitch filter before any edge detection is done. The I2C engine works at the byte level. It hands single-byte requests to an APB sequencer over a valid/ready pair. A request is held until the sequencer is idle and accepts it. The sequencer then runs a setup phase and an access phase, and it waits in the access phase for as long as PREADY stays low.

The APB side carries data in one of two ways:
- Writes replicate the byte across PWDATA and set a single PSTRB bit, chosen by the low address bits, so neighbouring bytes are never touched.
- Reads take the byte from the matching lane of PRDATA.

For reads, each byte is fetched over APB before its first bit goes onto SDA. The block never stretches SCL.

Top module: `i2c_apb_bridge`

## Requirements
- R1: After reset, both open-drain outputs are 1 (released), apb_psel is 0, and busy, bus_active and bus_selected are 0.
- R2: The block drives ACK (SDA low) on an address byte only when enable is 1 and the upper 7 bits of that byte equal own_addr. Any other address byte, or any address byte while enable is 0, gets no ACK and causes no APB access.
- R3: The status outputs behave as follows:
  - bus_active goes to 1 at a START and back to 0 at a STOP.
  - bus_selected is 1 from the ACK of this target's address until the next START or STOP.
  - last_addr holds the 7-bit address of the most recent address byte on the bus.
  - busy is 1 while a transfer to this target or an APB access is in progress.
- R4: In a write transfer (address byte bit 0 = 0), the first data byte sets pointer bits 15:8 and the second sets bits 7:0.
- R5: Each further write byte is ACKed and stored at the pointer, and the pointer then advances by one. The bytes just before and just after the written range keep their values.
- R6: An APB write drives the byte on every 8-bit lane of apb_pwdata and sets exactly one apb_pstrb bit: lane paddr[1:0] at the default 32-bit width. An APB read drives apb_pstrb to all zeros.
- R7: A read transfer (address byte bit 0 = 1) returns the bytes at pointer, pointer+1, and so on, MSB first, taking each byte from lane paddr[1:0] of apb_prdata. This holds for any start offset and any length up to twice the lane count. After the controller's NACK, SDA is released.
- R8: Each byte is one APB access: psel with penable low for one cycle, then penable high. The access holds its address and direction until pready is 1, for any number of wait states.
- R9: The pointer survives a STOP. A read with no pointer write continues from where the previous transfer ended.
- R10: scl_out is never 0.
- R11: A level change on SCL or SDA that lasts fewer than FILTER_LEN clock cycles is ignored, so an SDA glitch while SCL is high does not register a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | SCL line level |
| scl_out | output | 1 | SCL drive, 0 pulls low; always released |
| sda_in | input | 1 | SDA line level |
| sda_out | output | 1 | SDA drive, 0 pulls low |
| enable | input | 1 | Respond to the bus when 1 |
| own_addr | input | 7 | 7-bit target address |
| apb_psel | output | 1 | APB select |
| apb_penable | output | 1 | APB access phase |
| apb_pwrite | output | 1 | APB direction, 1 for write |
| apb_paddr | output | ADDR_W | APB byte address |
| apb_pwdata | output | DATA_W | APB write data, byte replicated |
| apb_pstrb | output | DATA_W/8 | APB byte strobes |
| apb_prdata | input | DATA_W | APB read data |
| apb_pready | input | 1 | APB ready, low inserts wait states |
| busy | output | 1 | Transfer or APB access in progress |
| bus_active | output | 1 | High between START and STOP |
| bus_selected | output | 1 | This target is addressed |
| last_addr | output | 7 | Last 7-bit address seen on the bus |

## Verification
A wrong pointer shows up as a read or write landing at the wrong address. On the APB side this is visible at the first access of the transfer. On the I2C side, a read shows it within one byte time. A wrong lane choice corrupts a neighbouring byte or returns a byte from the wrong lane, so the bench compares the entire memory image after every write. A bit-count or state error shifts the ACK slot, and the controller model sees the missing or extra ACK on the very next byte. Filter or edge-detect faults either turn a short glitch into a START, which raises bus_active within a few cycles, or make the block miss real frames.

// File: rtl/i2c_apb_pkg.sv
package i2c_apb_pkg;
  typedef enum logic [2:0] {
    T_IDLE,
    T_ADDR,
    T_ADDR_ACK,
    T_WR,
    T_WR_ACK,
    T_RD,
    T_RD_ACK
  } tgt_state_t;

  typedef enum logic [1:0] {
    A_IDLE,
    A_SETUP,
    A_ACCESS
  } apb_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  // the output follows the input only after LEN agreeing samples
  logic [LEN-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '1;
      dout <= 1'b1;
    end else begin
      hist <= {hist[LEN-2:0], din};
      if (&hist) dout <= 1'b1;
      else if (~|hist) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_apb_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl,
  input  logic             sda,
  input  logic             enable,
  input  logic [6:0]       own_addr,
  output logic             sda_drv,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [PTR_W-1:0] req_addr,
  output logic [7:0]       req_wdata,
  input  logic             rsp_valid,
  input  logic [7:0]       rsp_rdata,
  output logic             bus_active,
  output logic             bus_selected,
  output logic [6:0]       last_addr,
  output logic             idle
);
  tgt_state_t       state;
  logic             scl_q, sda_q;
  logic [2:0]       cnt;
  logic             got8;
  logic [7:0]       sh, tx;
  logic             rd_mode;
  logic [1:0]       wr_idx;
  logic [PTR_W-1:0] ptr;

  logic start_det, stop_det, rise, fall;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
  assign rise      = scl & ~scl_q;
  assign fall      = ~scl & scl_q;
  assign idle      = (state == T_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= T_IDLE;
      scl_q        <= 1'b1;
      sda_q        <= 1'b1;
      cnt          <= '0;
      got8         <= 1'b0;
      sh           <= '0;
      tx           <= '1;
      rd_mode      <= 1'b0;
      wr_idx       <= '0;
      ptr          <= '0;
      req_valid    <= 1'b0;
      req_write    <= 1'b0;
      req_addr     <= '0;
      req_wdata    <= '0;
      bus_active   <= 1'b0;
      bus_selected <= 1'b0;
      last_addr    <= '0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (rsp_valid) tx <= rsp_rdata;

      if (start_det) begin
        state        <= T_ADDR;
        cnt          <= '0;
        got8         <= 1'b0;
        bus_active   <= 1'b1;
        bus_selected <= 1'b0;
      end else if (stop_det) begin
        state        <= T_IDLE;
        bus_active   <= 1'b0;
        bus_selected <= 1'b0;
      end else begin
        unique case (state)
          T_ADDR, T_WR: begin
            if (rise && !got8) begin
              sh  <= {sh[6:0], sda};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) got8 <= 1'b1;
            end
            if (fall && got8) begin
              got8 <= 1'b0;
              cnt  <= '0;
              if (state == T_ADDR) begin
                last_addr <= sh[7:1];
                if (enable && sh[7:1] == own_addr) begin
                  bus_selected <= 1'b1;
                  rd_mode      <= sh[0];
                  wr_idx       <= '0;
                  state        <= T_ADDR_ACK;
                  if (sh[0]) begin
                    // prefetch the first read byte during the ACK slot
                    req_valid <= 1'b1;
                    req_write <= 1'b0;
                    req_addr  <= ptr;
                    ptr       <= ptr + 1'b1;
                    tx        <= '1;
                  end
                end else begin
                  state <= T_IDLE;
                end
              end else begin
                state <= T_WR_ACK;
                if (wr_idx == 2'd0) begin
                  ptr[PTR_W-1:8] <= sh;
                  wr_idx         <= 2'd1;
                end else if (wr_idx == 2'd1) begin
                  ptr[7:0] <= sh;
                  wr_idx   <= 2'd2;
                end else begin
                  req_valid <= 1'b1;
                  req_write <= 1'b1;
                  req_addr  <= ptr;
                  req_wdata <= sh;
                  ptr       <= ptr + 1'b1;
                end
              end
            end
          end
          T_ADDR_ACK: if (fall) begin
            cnt   <= '0;
            state <= rd_mode ? T_RD : T_WR;
          end
          T_WR_ACK: if (fall) begin
            cnt   <= '0;
            state <= T_WR;
          end
          T_RD: if (fall) begin
            if (cnt == 3'd7) state <= T_RD_ACK;
            else begin
              tx  <= {tx[6:0], 1'b1};
              cnt <= cnt + 3'd1;
            end
          end
          T_RD_ACK: begin
            if (rise) begin
              if (!sda) begin
                req_valid <= 1'b1;
                req_write <= 1'b0;
                req_addr  <= ptr;
                ptr       <= ptr + 1'b1;
                tx        <= '1;
              end else begin
                state <= T_IDLE;
              end
            end
            if (fall) begin
              cnt   <= '0;
              state <= T_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // registered open-drain drive: low for ACK slots and for 0 data bits
  always_ff @(posedge clk) begin
    if (rst) sda_drv <= 1'b1;
    else sda_drv <= ~((state == T_ADDR_ACK) || (state == T_WR_ACK) ||
                      (state == T_RD && !tx[7]));
  end
endmodule

// File: rtl/apb_byte_master.sv
module apb_byte_master
  import i2c_apb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [PTR_W-1:0]    req_addr,
  input  logic [7:0]          req_wdata,
  output logic                rsp_valid,
  output logic [7:0]          rsp_rdata,
  output logic                psel,
  output logic                penable,
  output logic                pwrite,
  output logic [ADDR_W-1:0]   paddr,
  output logic [DATA_W-1:0]   pwdata,
  output logic [DATA_W/8-1:0] pstrb,
  input  logic [DATA_W-1:0]   prdata,
  input  logic                pready,
  output logic                busy
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  apb_state_t       state;
  logic [PTR_W-1:0] addr_q;
  logic [7:0]       byte_q;
  logic             wr_q;
  logic [LANE_W-1:0] lane;
  logic [7:0]       rd_byte;

  generate
    if (LANES > 1) begin : g_multi
      assign lane = addr_q[LANE_W-1:0];
    end else begin : g_single
      assign lane = '0;
    end
  endgenerate

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < LANES; i++)
      if (lane == LANE_W'(i)) rd_byte = prdata[i*8 +: 8];
  end

  assign req_ready = (state == A_IDLE);
  assign psel      = (state != A_IDLE);
  assign penable   = (state == A_ACCESS);
  assign pwrite    = wr_q;
  assign paddr     = ADDR_W'(addr_q);
  assign pwdata    = {LANES{byte_q}};
  assign busy      = (state != A_IDLE);

  generate
    for (genvar gl = 0; gl < LANES; gl++) begin : g_strb
      assign pstrb[gl] = psel && wr_q && (lane == LANE_W'(gl));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= A_IDLE;
      addr_q    <= '0;
      byte_q    <= '0;
      wr_q      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        A_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          byte_q <= req_wdata;
          wr_q   <= req_write;
          state  <= A_SETUP;
        end
        A_SETUP: state <= A_ACCESS;
        A_ACCESS: if (pready) begin
          state     <= A_IDLE;
          rsp_valid <= !wr_q;
          rsp_rdata <= rd_byte;
        end
        default: state <= A_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_apb_bridge.sv
module i2c_apb_bridge #(
  parameter int FILTER_LEN = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_in,
  output logic                scl_out,
  input  logic                sda_in,
  output logic                sda_out,
  input  logic                enable,
  input  logic [6:0]          own_addr,
  output logic                apb_psel,
  output logic                apb_penable,
  output logic                apb_pwrite,
  output logic [ADDR_W-1:0]   apb_paddr,
  output logic [DATA_W-1:0]   apb_pwdata,
  output logic [DATA_W/8-1:0] apb_pstrb,
  input  logic [DATA_W-1:0]   apb_prdata,
  input  logic                apb_pready,
  output logic                busy,
  output logic                bus_active,
  output logic                bus_selected,
  output logic [6:0]          last_addr
);
  localparam int PTR_W = 16;

  logic [1:0] raw, filt;
  assign raw = {scl_in, sda_in};

  generate
    for (genvar gi = 0; gi < 2; gi++) begin : g_filt
      i2c_line_filter #(.LEN(FILTER_LEN)) u_filt (
        .clk (clk),
        .rst (rst),
        .din (raw[gi]),
        .dout(filt[gi])
      );
    end
  endgenerate

  logic             req_valid, req_ready, req_write, rsp_valid;
  logic [PTR_W-1:0] req_addr;
  logic [7:0]       req_wdata, rsp_rdata;
  logic             eng_idle, apb_busy;

  i2c_target_fsm #(.PTR_W(PTR_W)) u_tgt (
    .clk         (clk),
    .rst         (rst),
    .scl         (filt[1]),
    .sda         (filt[0]),
    .enable      (enable),
    .own_addr    (own_addr),
    .sda_drv     (sda_out),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .bus_active  (bus_active),
    .bus_selected(bus_selected),
    .last_addr   (last_addr),
    .idle        (eng_idle)
  );

  apb_byte_master #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_apb (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .psel     (apb_psel),
    .penable  (apb_penable),
    .pwrite   (apb_pwrite),
    .paddr    (apb_paddr),
    .pwdata   (apb_pwdata),
    .pstrb    (apb_pstrb),
    .prdata   (apb_prdata),
    .pready   (apb_pready),
    .busy     (apb_busy)
  );

  assign scl_out = 1'b1;
  assign busy    = !eng_idle || apb_busy;
endmodule

// File: rtl/i2c_apb_bridge_sva.sv
module i2c_apb_bridge_sva #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                psel,
  input logic                penable,
  input logic                pwrite,
  input logic [ADDR_W-1:0]   paddr,
  input logic [DATA_W-1:0]   pwdata,
  input logic [DATA_W/8-1:0] pstrb,
  input logic                pready,
  input logic                sda_out,
  input logic                bus_active,
  input logic                bus_selected
);
  localparam int LANES = DATA_W / 8;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

  a_r8_setup_then_access: assert property (@(posedge clk) disable iff (rst)
    psel && !penable |=> psel && penable);

  a_r8_hold_in_wait: assert property (@(posedge clk) disable iff (rst)
    psel && penable && !pready |=> psel && penable && $stable(paddr) && $stable(pwrite));

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
    psel && pwrite |-> $countones(pstrb) == 1);

  a_r6_strobe_lane: assert property (@(posedge clk) disable iff (rst)
    psel && pwrite |-> pstrb[paddr[LW-1:0]]);

  a_r6_no_strobe_read: assert property (@(posedge clk) disable iff (rst)
    psel && !pwrite |-> pstrb == '0);

  a_r6_replicated: assert property (@(posedge clk) disable iff (rst)
    psel && pwrite |-> pwdata == {LANES{pwdata[7:0]}});

  a_r3_selected_in_frame: assert property (@(posedge clk) disable iff (rst)
    bus_selected |-> bus_active);

  a_r2_drive_when_selected: assert property (@(posedge clk) disable iff (rst)
    !sda_out |-> bus_selected);
endmodule

bind i2c_apb_bridge i2c_apb_bridge_sva #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .psel        (apb_psel),
  .penable     (apb_penable),
  .pwrite      (apb_pwrite),
  .paddr       (apb_paddr),
  .pwdata      (apb_pwdata),
  .pstrb       (apb_pstrb),
  .pready      (apb_pready),
  .sda_out     (sda_out),
  .bus_active  (bus_active),
  .bus_selected(bus_selected)
);

// File: tb/sim_i2c_apb_bridge.sv
`timescale 1ns/1ps
module sim_i2c_apb_bridge;
  localparam int FILTER_LEN = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int LANES  = DATA_W / 8;
  localparam int Q      = 8;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, glitch_n = 1'b1;
  logic scl_out, sda_out, scl_line, sda_line;
  logic enable = 1'b1;
  logic apb_psel, apb_penable, apb_pwrite, apb_pready = 1'b1;
  logic [ADDR_W-1:0] apb_paddr;
  logic [DATA_W-1:0] apb_pwdata, apb_prdata;
  logic [LANES-1:0] apb_pstrb;
  logic busy, bus_active, bus_selected;
  logic [6:0] last_addr;

  assign scl_line = scl_m & scl_out;
  assign sda_line = sda_m & sda_out & glitch_n;

  i2c_apb_bridge #(.FILTER_LEN(FILTER_LEN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl_line), .scl_out(scl_out),
    .sda_in(sda_line), .sda_out(sda_out), .enable(enable), .own_addr(OWN),
    .apb_psel(apb_psel), .apb_penable(apb_penable), .apb_pwrite(apb_pwrite),
    .apb_paddr(apb_paddr), .apb_pwdata(apb_pwdata), .apb_pstrb(apb_pstrb),
    .apb_prdata(apb_prdata), .apb_pready(apb_pready), .busy(busy),
    .bus_active(bus_active), .bus_selected(bus_selected), .last_addr(last_addr)
  );

  // memory behind the APB completer, 1 KiB window of byte addresses
  logic [7:0] mbytes [0:1023];
  logic [7:0] exp_m  [0:1023];
  int checks = 0, errors = 0, apb_done = 0, scl_low = 0, wcnt = 0;
  bit finished = 0;

  always_comb
    for (int j = 0; j < LANES; j++)
      apb_prdata[j*8 +: 8] = mbytes[{apb_paddr[9:2], 2'(j)}];

  always @(negedge clk) begin
    if (apb_psel && apb_penable) begin
      apb_pready <= (wcnt >= 3) || ($urandom_range(0, 1) == 1);
      wcnt <= wcnt + 1;
    end else begin
      apb_pready <= ($urandom_range(0, 1) == 1);
      wcnt <= 0;
    end
    if (!scl_out) scl_low <= scl_low + 1;
  end

  always @(posedge clk)
    if (apb_psel && apb_penable && apb_pready) begin
      apb_done <= apb_done + 1;
      if (apb_pwrite)
        for (int j = 0; j < LANES; j++)
          if (apb_pstrb[j]) mbytes[{apb_paddr[9:2], 2'(j)}] <= apb_pwdata[j*8 +: 8];
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int first_diff();
    for (int i = 0; i < 1024; i++)
      if (mbytes[i] !== exp_m[i]) return i;
    return -1;
  endfunction

  function automatic logic [9:0] idx(input logic [15:0] p, input int k);
    logic [15:0] s = p + 16'(k);
    return s[9:0];
  endfunction

  task automatic wait_q(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q(); wait_q();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(); scl_m = 1'b1; wait_q(); wait_q(); scl_m = 1'b0; wait_q();
    end
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    ack = !sda_line;
    wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic rbyte(output logic [7:0] d, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
      d[i] = sda_line;
      wait_q(); scl_m = 1'b0; wait_q();
    end
    sda_m = nack; wait_q(); scl_m = 1'b1; wait_q(); wait_q(); scl_m = 1'b0; wait_q();
  endtask

  logic [15:0] cur_ptr = 16'h0;
  int exp_apb = 0;

  task automatic i2c_wr(input logic [15:0] ptr, input int len, input string req);
    logic ack;
    logic [7:0] d;
    int bad;
    i2c_start();
    wbyte({OWN, 1'b0}, ack);
    chk("R2 own address ACK", 32'(ack), 1);
    chk("R3 selected after ACK", {bus_active, bus_selected, busy}, 3'b111);
    chk("R3 last_addr", 32'(last_addr), 32'(OWN));
    wbyte(ptr[15:8], ack);
    wbyte(ptr[7:0], ack);
    for (int k = 0; k < len; k++) begin
      d = 8'($urandom);
      wbyte(d, ack);
      exp_m[idx(ptr, k)] = d;
      chk("R5 data byte ACK", 32'(ack), 1);
    end
    i2c_stop();
    repeat (4) @(negedge clk);
    exp_apb += len;
    cur_ptr = ptr + 16'(len);
    bad = first_diff();
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s memory[%0h] actual=%0h expected=%0h", req, bad, mbytes[bad], exp_m[bad]);
    end
    chk("R3 idle after STOP", {bus_active, bus_selected, busy}, 3'b000);
  endtask

  task automatic i2c_rd(input bit setptr, input logic [15:0] ptr_in, input int len, input string req);
    logic ack;
    logic [7:0] d;
    logic [15:0] ptr;
    ptr = setptr ? ptr_in : cur_ptr;
    i2c_start();
    if (setptr) begin
      wbyte({OWN, 1'b0}, ack);
      wbyte(ptr[15:8], ack);
      wbyte(ptr[7:0], ack);
      i2c_rstart();
    end
    wbyte({OWN, 1'b1}, ack);
    chk("R2 read address ACK", 32'(ack), 1);
    for (int k = 0; k < len; k++) begin
      rbyte(d, k == len - 1);
      chk(req, 32'(d), 32'(exp_m[idx(ptr, k)]));
    end
    chk("R7 SDA released after NACK", 32'(sda_out), 1);
    i2c_stop();
    repeat (4) @(negedge clk);
    exp_apb += len;
    cur_ptr = ptr + 16'(len);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    int seen;
    int r_seed;
    r_seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < 1024; i++) begin
      mbytes[i] = 8'($urandom);
      exp_m[i]  = mbytes[i];
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 sda/scl released", {sda_out, scl_out}, 2'b11);
    chk("R1 psel low", 32'(apb_psel), 0);
    chk("R1 status low", {busy, bus_active, bus_selected}, 3'b000);

    // R11 short SDA glitch while SCL high is not a START
    seen = 0;
    glitch_n = 1'b0;
    repeat (FILTER_LEN - 1) @(negedge clk);
    glitch_n = 1'b1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (bus_active) seen++;
    end
    chk("R11 glitch ignored", 32'(seen), 0);

    // R2/R3 foreign address
    i2c_start();
    chk("R3 bus_active after START", 32'(bus_active), 1);
    wbyte({7'h15, 1'b0}, ack);
    chk("R2 foreign address NACK", 32'(ack), 0);
    chk("R3 last_addr foreign", 32'(last_addr), 32'h15);
    chk("R3 not selected", 32'(bus_selected), 0);
    i2c_stop();
    chk("R3 bus_active cleared", 32'(bus_active), 0);
    chk("R2 no APB access for foreign address", 32'(apb_done), 0);

    // R2 disabled
    enable = 1'b0;
    i2c_start();
    wbyte({OWN, 1'b0}, ack);
    chk("R2 NACK when disabled", 32'(ack), 0);
    i2c_stop();
    enable = 1'b1;
    chk("R2 no APB access when disabled", 32'(apb_done), 0);

    // R4 big-endian pointer
    i2c_wr(16'h0102, 2, "R4 pointer order");
    i2c_wr(16'h0201, 1, "R4 pointer order swapped");

    // R5/R7 every lane offset, short and long
    for (int o = 0; o < LANES; o++) begin
      i2c_wr(16'h0180 + 16'(o * 16), 1, "R5 single byte write");
      i2c_rd(1'b1, 16'h0180 + 16'(o * 16), 1, "R7 single byte read");
      i2c_wr(16'h0300 + 16'(o * 16) + 16'(o), 2 * LANES - 1, "R5 long unaligned write");
      i2c_rd(1'b1, 16'h0300 + 16'(o * 16) + 16'(o), 2 * LANES - 1, "R7 long unaligned read");
    end

    // R9 pointer kept across STOP
    i2c_wr(16'h0240, 3, "R9 write before continue");
    i2c_rd(1'b0, 16'h0, 3, "R9 read continues after write");
    i2c_rd(1'b0, 16'h0, 2, "R9 read continues after read");

    // random mix
    for (int n = 0; n < 6; n++) begin
      logic [15:0] p;
      int len;
      p   = 16'h0100 + 16'($urandom_range(0, 16'h02E0));
      len = $urandom_range(1, 2 * LANES);
      i2c_wr(p, len, "R5 random write");
      i2c_rd(1'b1, p, len, "R7 random read");
    end

    chk("R8 one APB access per byte", 32'(apb_done), 32'(exp_apb));
    chk("R10 SCL never driven", 32'(scl_low), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule